// File: doc/BRIEF.md
# Key-Driven Binary Code Block Generator

This block turns a compact 17-byte key into a binary code block and streams it out at one chip per clock, row by row. The key holds a 6-bit circular row rotation and two 8x8 binary matrices. The 64x64 base block is formed from the Kronecker product of those two matrices. Odd rows in its lower half are then negated, and the rows are rotated by the key's rotation amount. Every chip is computed as it is needed, so no full block is ever stored.

In extended mode, each pass emits 128 rows. The first 64 rows are the base block. The next 64 rows are the base block again, with its odd rows negated. A repeat field sets how many passes run back to back with no gap. A host shifts the key in one byte at a time while the block is idle, then pulses start. Downstream logic takes the chips together with row and block boundary flags.

Top module: `code_block_gen`

## Requirements
- R1: After reset, `chip_valid`, `row_end` and `block_end` are all low, and they stay low until a start is accepted.
- R2: Key bytes are taken in arrival order while the block is idle. Byte 0 supplies the rotation, and only its low 6 bits are used. Bytes 1 to 8 are rows 0 to 7 of matrix A. Bytes 9 to 16 are rows 0 to 7 of matrix B. Bit 7 of each byte is column 0. An accepted start resets the byte counter.
- R3: Chip value 0 stands for +1 and value 1 stands for -1. Before inversion and rotation, the chip at row p, column c is A[p/8][c/8] XOR B[p%8][c%8]. Chips leave row-major, with column 0 first.
- R4: Before rotation, every odd row p in the range 32 to 63 is inverted.
- R5: Base output row i carries the pre-rotation row (i + rotation) mod 64.
- R6: With `szc_mode`=1, each pass is 128 rows. Rows 64 to 127 repeat rows 0 to 63, and odd rows within that second copy are inverted. With `szc_mode`=0, each pass is the 64-row base block.
- R7: One start produces `rep_count`+1 passes. `chip_valid` is high on every cycle from the first chip to the last chip, with no gap in between.
- R8: `row_end` is high exactly on the chip in column 63 of each row.
- R9: `block_end` is high only on the final chip of the final pass. `chip_valid` is low on the next cycle.
- R10: While chips are streaming, `start`, `rep_count`, `szc_mode` and key bytes are ignored. The running stream continues unchanged, and the stored key is still intact for the next run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| key_byte | input | 8 | Key byte being loaded |
| key_valid | input | 1 | Strobe that writes `key_byte` into the next key slot |
| start | input | 1 | Begins streaming when the block is idle |
| szc_mode | input | 1 | 1 selects 128-row extended passes, 0 selects 64-row base passes |
| rep_count | input | 4 | Number of passes minus one, taken at start |
| chip_out | output | 1 | Current chip (0 = +1, 1 = -1) |
| chip_valid | output | 1 | `chip_out` is valid |
| row_end | output | 1 | Last chip of a row |
| block_end | output | 1 | Last chip of the whole run |

## Verification
The hardest condition to reach from the ports is a run in which the block is busy and receives a second start, a different repeat field and stray key bytes all at once. The bench drives exactly that partway through a two-pass extended run. It then checks that the chip count and every chip value still match the original request. A later run is made without reloading the key, which shows the stored key was never overwritten. Rotation wrap-around and the lower-half and second-copy inversions are each made visible on their own. One key uses all-zero matrices, and another uses a rotation byte with its upper bits set. Randomly keyed runs then mix the two modes.

// File: rtl/cbg_pkg.sv
// Package cbg_pkg: types shared by the code block generator modules.
// Assumes nothing beyond being compiled before the modules that import it.
package cbg_pkg;
    typedef enum logic {
        CBG_IDLE = 1'b0,
        CBG_RUN  = 1'b1
    } cbg_state_e;
endpackage

// File: rtl/cbg_key_store.sv
// cbg_key_store: captures the key bytes while the generator is idle.
// Slot 0 holds the rotation and slots 1..2*SUB hold the rows of A, then B.
// Assumes SUB is a power of two, and that a load always begins at slot 0
// (after reset or after an accepted start).
module cbg_key_store #(
    parameter int SUB = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [SUB-1:0]                byte_in,
    input  logic                          byte_valid,
    input  logic                          busy,
    input  logic                          ptr_clear,
    output logic [2*$clog2(SUB)-1:0]      rot_o,
    output logic [SUB-1:0][SUB-1:0]       mat_a_o,
    output logic [SUB-1:0][SUB-1:0]       mat_b_o
);
    localparam int SB        = $clog2(SUB);
    localparam int LG        = 2 * SB;
    localparam int KEY_BYTES = 1 + 2 * SUB;
    localparam int PW        = $clog2(KEY_BYTES);

    logic [PW-1:0]            ptr_q;
    logic [PW-1:0]            slot_m1;
    logic [LG-1:0]            rot_q;
    logic [SUB-1:0][SUB-1:0]  a_q;
    logic [SUB-1:0][SUB-1:0]  b_q;
    logic                     wr_en;

    assign wr_en   = byte_valid && !busy;
    assign slot_m1 = ptr_q - PW'(1);

    // Write pointer: counts accepted bytes modulo the key length.
    always_ff @(posedge clk) begin
        if (!rst_n || ptr_clear) begin
            ptr_q <= '0;
        end else if (wr_en) begin
            ptr_q <= (ptr_q == PW'(KEY_BYTES - 1)) ? '0 : ptr_q + PW'(1);
        end
    end

    // Key registers: route each accepted byte to its slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rot_q <= '0;
            a_q   <= '0;
            b_q   <= '0;
        end else if (wr_en) begin
            if (ptr_q == '0) begin
                rot_q <= byte_in[LG-1:0];
            end else if (slot_m1[SB] == 1'b0) begin
                a_q[slot_m1[SB-1:0]] <= byte_in;
            end else begin
                b_q[slot_m1[SB-1:0]] <= byte_in;
            end
        end
    end

    assign rot_o   = rot_q;
    assign mat_a_o = a_q;
    assign mat_b_o = b_q;

    AST_KEY_FROZEN_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(rot_q) && $stable(a_q) && $stable(b_q))); // R10
endmodule

// File: rtl/cbg_sequencer.sv
// cbg_sequencer: walks column, row, copy and pass counters for one run.
// Assumes each counter range is a power of two (64 columns and 64 rows for SUB=8).
// Inputs are sampled only when a start is accepted while idle.
module cbg_sequencer #(
    parameter int LG    = 6,
    parameter int REP_W = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          szc_mode,
    input  logic [REP_W-1:0] rep_count,
    output logic          fire,
    output logic          accept,
    output logic [LG-1:0] row_o,
    output logic [LG-1:0] col_o,
    output logic          copy_o,
    output logic          col_last,
    output logic          chip_last
);
    import cbg_pkg::*;

    cbg_state_e        state_q;
    logic [LG-1:0]     col_q;
    logic [LG-1:0]     row_q;
    logic              copy_q;
    logic              szc_q;
    logic [REP_W-1:0]  reps_left_q;
    logic              row_last;
    logic              pass_last;

    assign fire      = (state_q == CBG_RUN);
    assign accept    = start && (state_q == CBG_IDLE);
    assign col_last  = &col_q;
    assign row_last  = &row_q;
    assign pass_last = row_last && (copy_q || !szc_q);
    assign chip_last = fire && col_last && pass_last && (reps_left_q == '0);

    // Run control: leave idle on an accepted start, return after the last chip.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= CBG_IDLE;
            szc_q       <= 1'b0;
            reps_left_q <= '0;
        end else if (accept) begin
            state_q     <= CBG_RUN;
            szc_q       <= szc_mode;
            reps_left_q <= rep_count;
        end else if (fire && col_last && pass_last) begin
            if (reps_left_q == '0) begin
                state_q <= CBG_IDLE;
            end else begin
                reps_left_q <= reps_left_q - REP_W'(1);
            end
        end
    end

    // Position counters: column fastest, then row, then copy.
    always_ff @(posedge clk) begin
        if (!rst_n || accept) begin
            col_q  <= '0;
            row_q  <= '0;
            copy_q <= 1'b0;
        end else if (fire) begin
            col_q <= col_q + LG'(1);
            if (col_last) begin
                row_q <= row_q + LG'(1);
                if (row_last) begin
                    copy_q <= szc_q && !copy_q;
                end
            end
        end
    end

    assign row_o  = row_q;
    assign col_o  = col_q;
    assign copy_o = copy_q;

    AST_COL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !col_last) |=> (col_q == $past(col_q) + LG'(1))); // R3
    AST_RUN_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !chip_last) |=> fire); // R7
    AST_SECOND_COPY_ONLY_EXTENDED: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && copy_q) |-> szc_q); // R6
endmodule

// File: rtl/cbg_chip_calc.sv
// cbg_chip_calc: combinational value of one chip from the key and its position.
// Assumes SUB is a power of two, so that reversing a column index is a bitwise NOT.
module cbg_chip_calc #(
    parameter int SUB = 8
) (
    input  logic [2*$clog2(SUB)-1:0]  rot,
    input  logic [SUB-1:0][SUB-1:0]   mat_a,
    input  logic [SUB-1:0][SUB-1:0]   mat_b,
    input  logic [2*$clog2(SUB)-1:0]  row,
    input  logic [2*$clog2(SUB)-1:0]  col,
    input  logic                      copy,
    output logic                      chip
);
    localparam int SB = $clog2(SUB);
    localparam int LG = 2 * SB;

    logic [LG-1:0]  pre_row;
    logic [SUB-1:0] a_row;
    logic [SUB-1:0] b_row;
    logic [SB-1:0]  a_bit_idx;
    logic [SB-1:0]  b_bit_idx;
    logic           half_inv;
    logic           copy_inv;

    // Chip value: Kronecker XOR, lower-half odd-row flip, second-copy odd-row flip.
    always_comb begin
        pre_row   = row + rot;
        a_row     = mat_a[pre_row[LG-1:SB]];
        b_row     = mat_b[pre_row[SB-1:0]];
        a_bit_idx = ~col[LG-1:SB];
        b_bit_idx = ~col[SB-1:0];
        half_inv  = pre_row[LG-1] & pre_row[0];
        copy_inv  = copy & row[0];
        chip      = a_row[a_bit_idx] ^ b_row[b_bit_idx] ^ half_inv ^ copy_inv;
    end
endmodule

// File: rtl/code_block_gen.sv
// code_block_gen: top level. Loads a key, then streams the code block one
// registered chip per cycle. The output flags are aligned with chip_out.
// Assumes SUB is a power of two and that at least 2*$clog2(SUB) key-byte
// bits exist for the rotation.
module code_block_gen #(
    parameter int SUB   = 8,
    parameter int REP_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SUB-1:0]    key_byte,
    input  logic              key_valid,
    input  logic              start,
    input  logic              szc_mode,
    input  logic [REP_W-1:0]  rep_count,
    output logic              chip_out,
    output logic              chip_valid,
    output logic              row_end,
    output logic              block_end
);
    localparam int LG = 2 * $clog2(SUB);

    logic                     fire;
    logic                     accept;
    logic [LG-1:0]            row;
    logic [LG-1:0]            col;
    logic                     copy;
    logic                     col_last;
    logic                     chip_last;
    logic [LG-1:0]            rot;
    logic [SUB-1:0][SUB-1:0]  mat_a;
    logic [SUB-1:0][SUB-1:0]  mat_b;
    logic                     chip_d;

    cbg_key_store #(.SUB(SUB)) u_keys (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_in   (key_byte),
        .byte_valid(key_valid),
        .busy      (fire),
        .ptr_clear (accept),
        .rot_o     (rot),
        .mat_a_o   (mat_a),
        .mat_b_o   (mat_b)
    );

    cbg_sequencer #(.LG(LG), .REP_W(REP_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .szc_mode (szc_mode),
        .rep_count(rep_count),
        .fire     (fire),
        .accept   (accept),
        .row_o    (row),
        .col_o    (col),
        .copy_o   (copy),
        .col_last (col_last),
        .chip_last(chip_last)
    );

    cbg_chip_calc #(.SUB(SUB)) u_calc (
        .rot  (rot),
        .mat_a(mat_a),
        .mat_b(mat_b),
        .row  (row),
        .col  (col),
        .copy (copy),
        .chip (chip_d)
    );

    // Output register: chip and its flags leave together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chip_out   <= 1'b0;
            chip_valid <= 1'b0;
            row_end    <= 1'b0;
            block_end  <= 1'b0;
        end else begin
            chip_out   <= fire & chip_d;
            chip_valid <= fire;
            row_end    <= fire & col_last;
            block_end  <= chip_last;
        end
    end

    AST_ROW_END_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        row_end |-> chip_valid); // R8
    AST_BLOCK_END_ON_ROW_END: assert property (@(posedge clk) disable iff (!rst_n)
        block_end |-> row_end); // R9
    AST_QUIET_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
        block_end |=> !chip_valid); // R9
    AST_NO_FLAG_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_valid |-> (!row_end && !block_end && !chip_out)); // R1
endmodule

// File: tb/code_block_gen_test.sv
// code_block_gen_test: self-checking bench. It uses a reference chip function
// built from the requirements, random keys drawn from a fixed seed, and directed
// corner cases.
module code_block_gen_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 195000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] key_byte = '0;
    logic       key_valid = 1'b0;
    logic       start = 1'b0;
    logic       szc_mode = 1'b0;
    logic [3:0] rep_count = '0;
    logic       chip_out;
    logic       chip_valid;
    logic       row_end;
    logic       block_end;

    int   n_checks = 0;
    int   n_errors = 0;
    bit   finished = 1'b0;
    logic [7:0] kb [17];

    code_block_gen uut (
        .clk(clk), .rst_n(rst_n), .key_byte(key_byte), .key_valid(key_valid),
        .start(start), .szc_mode(szc_mode), .rep_count(rep_count),
        .chip_out(chip_out), .chip_valid(chip_valid),
        .row_end(row_end), .block_end(block_end)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference value for row r of a pass (0..127) and column c.
    function automatic bit ref_chip(input int r, input int c);
        int  i, p;
        bit  a, b, hi, ci;
        i  = r % 64;
        p  = (i + int'(kb[0] & 8'h3f)) % 64;
        a  = kb[1 + p/8][7 - c/8];
        b  = kb[9 + p%8][7 - c%8];
        hi = (p >= 32) && (p % 2 == 1);
        ci = (r >= 64) && (i % 2 == 1);
        return a ^ b ^ hi ^ ci;
    endfunction

    task automatic load_key();
        for (int k = 0; k < 17; k++) begin
            @(negedge clk);
            key_byte  = kb[k];
            key_valid = 1'b1;
        end
        @(negedge clk);
        key_valid = 1'b0;
    endtask

    task automatic random_key();
        for (int k = 0; k < 17; k++) kb[k] = 8'($urandom);
    endtask

    // Starts one run and compares every chip and flag. With poke set, a second
    // start, a new repeat field and stray key bytes are driven during the run.
    task automatic run_block(input bit szc, input int reps, input bit poke, input string tag);
        int rows, total, n, wait_cyc, val_err, re_err, be_err, gap;
        int first_bad_act, first_bad_exp;
        rows = szc ? 128 : 64;
        total = (reps + 1) * rows * 64;
        n = 0; wait_cyc = 0; val_err = 0; re_err = 0; be_err = 0; gap = 0;
        first_bad_act = 0; first_bad_exp = 0;
        @(negedge clk);
        start = 1'b1; szc_mode = szc; rep_count = 4'(reps);
        @(negedge clk);
        start = 1'b0;
        while (n < total && wait_cyc < total + 20) begin
            @(negedge clk);
            wait_cyc++;
            start = 1'b0; key_valid = 1'b0;
            if (chip_valid) begin
                int r, c;
                bit e;
                r = (n / 64) % rows;
                c = n % 64;
                e = ref_chip(r, c);
                if (chip_out !== e) begin
                    if (val_err == 0) begin first_bad_act = chip_out; first_bad_exp = e; end
                    val_err++;
                end
                if (row_end !== (c == 63)) re_err++;
                if (block_end !== (n == total - 1)) be_err++;
                n++;
                if (poke && n == 100) begin
                    start = 1'b1; szc_mode = ~szc; rep_count = 4'(reps + 3);
                    key_byte = 8'h5a; key_valid = 1'b1;
                end
            end else if (n > 0) begin
                gap++;
            end
        end
        start = 1'b0; key_valid = 1'b0;
        // R3 R4 R5 R6: every chip equals the reference value
        check(val_err == 0, {"R3 R4 R5 R6 chip values ", tag}, first_bad_act, first_bad_exp);
        // R7: chip count and continuity
        check(n == total && gap == 0, {"R7 chip count ", tag}, n, total);
        // R8: row_end placement
        check(re_err == 0, {"R8 row_end mismatches ", tag}, re_err, 0);
        // R9: block_end on last chip only, then quiet
        check(be_err == 0, {"R9 block_end mismatches ", tag}, be_err, 0);
        @(negedge clk);
        check(chip_valid == 1'b0, {"R9 valid after end ", tag}, chip_valid, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: outputs quiet during and just after reset
        check(!chip_valid && !row_end && !block_end, "R1 reset outputs", chip_valid, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(!chip_valid && !row_end && !block_end, "R1 idle outputs", chip_valid, 0);

        // R4 R6: zero matrices, no rotation, so only the inversions show
        for (int k = 0; k < 17; k++) kb[k] = 8'h00;
        load_key();
        run_block(1'b1, 0, 1'b0, "zero key extended");

        // R2 R5: rotation byte with upper bits set, only 5 from 8'hC5 is used
        random_key();
        kb[0] = 8'hc5;
        load_key();
        run_block(1'b0, 2, 1'b0, "rotation 5 base x3");

        // R5: rotation 63 wraps
        random_key();
        kb[0] = 8'h3f;
        load_key();
        run_block(1'b0, 0, 1'b0, "rotation 63");

        // R10: interference while busy, then reuse the key without reloading
        random_key();
        load_key();
        run_block(1'b1, 1, 1'b1, "busy poke R10");
        run_block(1'b0, 0, 1'b0, "key kept R10");

        // Random keys, mixed modes
        for (int t = 0; t < 5; t++) begin
            random_key();
            load_key();
            run_block(1'($urandom % 2), int'($urandom % 2), 1'b0, "random R2");
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", WATCHDOG, 0);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule